// File: doc/BRIEF.md
# Four-Phase Handshake Word Link

This block joins a clocked sender and a clocked receiver over a request/acknowledge link. For every word the sender drives the link data, holds it for a programmed setup interval, and then raises request. The receiver waits a programmed hold interval, captures the word and raises acknowledge. The sender keeps request high for the same hold interval after acknowledge, then drops it. The receiver drops acknowledge in response. Only after acknowledge has returned low does the sender present anything new.

A single `go_i` pulse opens a session that moves one or more words. A session flag stays high on the link for the whole burst. Each word still makes its own full four-phase exchange. No address travels on the link. The receiver starts an address counter at a base value when the session flag rises and steps it by one for every word it accepts. The user side feeds words through `data_i`, and a `take_o` strobe marks each word as it is consumed.

Top module: `hs_link_top`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no session started, `link_req_o`, `link_ack_o`, `link_sess_o`, `done_o`, `rx_valid_o` and `take_o` are all 0.
- R2: On the link the phases run strictly in this order: request rises while acknowledge is low, acknowledge rises while request is high, request falls while acknowledge is high, and acknowledge falls while request is low.
- R3: `link_data_o` has held its value for at least SETUP_CYC cycles when request rises, exactly SETUP_CYC cycles after the word is loaded, and it does not change while request is high and acknowledge is still low.
- R4: Acknowledge rises exactly HOLD_CYC cycles after request rises.
- R5: Request falls exactly HOLD_CYC cycles after acknowledge rises.
- R6: `burst_len_i` holds the number of words minus one and is sampled at session start. A session moves exactly that many words, keeps `link_sess_o` high until it ends, and pulses `take_o` once per word. `data_i` is loaded at the clock edge where `take_o` is high.
- R7: `rx_valid_o` is a one-cycle pulse raised at the edge where acknowledge rises. `rx_data_o` holds the received word, and words arrive in the order they were sent.
- R8: The first word of every session has `rx_addr_o` equal to BASE_ADDR. Each later word adds one, wrapping modulo 2^AW, and a new session or a reset starts again from BASE_ADDR.
- R9: The sender waits for acknowledge to return low before the next word or session. Each word takes SETUP_CYC+2*HOLD_CYC+2 cycles, and `done_o` is a one-cycle pulse N*(SETUP_CYC+2*HOLD_CYC+2) cycles after the edge that accepts `go_i` for an N-word session.
- R10: `go_i` held high while a session is in progress has no effect: the word count and the timing of that session are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Start a session when the link is idle |
| burst_len_i | input | LW | Words in the session minus one |
| data_i | input | DW | Next word to send, loaded when take_o is high |
| take_o | output | 1 | The word on data_i is consumed at this edge |
| done_o | output | 1 | One-cycle pulse when the session completes |
| rx_data_o | output | DW | Last word captured by the receiver |
| rx_addr_o | output | AW | Implicit address of the last captured word |
| rx_valid_o | output | 1 | One-cycle pulse per captured word |
| link_req_o | output | 1 | Link request, driven by the sender |
| link_ack_o | output | 1 | Link acknowledge, driven by the receiver |
| link_sess_o | output | 1 | Link session flag, high for the whole burst |
| link_data_o | output | DW | Link data lines |

## Verification
The bench sweeps every burst length from one to eight words, each with three data seeds. Every word value comes from a quadratic in its index, so a dropped, repeated or reordered word changes the data it sees. The base address is set close to the top of the address range, which makes longer bursts wrap and tells a correct modulo step apart from a saturating or non-wrapping counter. For each edge on the link the bench measures the exact cycle distance, so an off-by-one in either hold count or in the setup count shows up directly. Other runs hold `go_i` high through the whole session, and one run applies reset in the middle of a burst. These show whether a busy sender ignores a restart and whether the address counter returns to its base.

// File: rtl/hs_link_pkg.sv
`timescale 1ns/1ps
package hs_link_pkg;
  typedef enum logic [1:0] {TX_IDLE, TX_SETUP, TX_REQ, TX_REL} tx_state_e;
  typedef enum logic [0:0] {RX_IDLE, RX_ACK} rx_state_e;

  function automatic int unsigned cnt_width(int unsigned a, int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return $clog2(m + 1) + 1;
  endfunction
endpackage

// File: rtl/hs_link_tx.sv
`timescale 1ns/1ps
module hs_link_tx
  import hs_link_pkg::*;
#(
  parameter int DW        = 8,
  parameter int LW        = 3,
  parameter int SETUP_CYC = 3,
  parameter int HOLD_CYC  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [LW-1:0] len_i,
  input  logic [DW-1:0] data_i,
  input  logic          ack_i,
  output logic          take_o,
  output logic          done_o,
  output logic          req_o,
  output logic          sess_o,
  output logic [DW-1:0] data_o
);
  localparam int CW = cnt_width(SETUP_CYC, HOLD_CYC);
  localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_CYC - 1);

  tx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [LW-1:0] left_q;
  logic [DW-1:0] data_q;
  logic          req_q, sess_q, done_q;
  logic          start, next_word;

  assign start     = (state_q == TX_IDLE) && go_i && !ack_i;
  assign next_word = (state_q == TX_REL) && !ack_i && (left_q != '0);
  assign take_o    = start | next_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      left_q  <= '0;
      data_q  <= '0;
      req_q   <= 1'b0;
      sess_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        TX_IDLE: if (start) begin
          data_q  <= data_i;
          left_q  <= len_i;
          sess_q  <= 1'b1;
          cnt_q   <= '0;
          state_q <= TX_SETUP;
        end
        TX_SETUP: begin
          if (cnt_q == SETUP_LAST) begin
            cnt_q   <= '0;
            req_q   <= 1'b1;
            state_q <= TX_REQ;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        TX_REQ: if (ack_i) begin
          // count acknowledge-high cycles before releasing request
          if (cnt_q == HOLD_LAST) begin
            cnt_q   <= '0;
            req_q   <= 1'b0;
            state_q <= TX_REL;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        TX_REL: if (!ack_i) begin
          if (left_q == '0) begin
            sess_q  <= 1'b0;
            done_q  <= 1'b1;
            state_q <= TX_IDLE;
          end else begin
            left_q  <= left_q - 1'b1;
            data_q  <= data_i;
            state_q <= TX_SETUP;
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assign req_o  = req_q;
  assign sess_o = sess_q;
  assign done_o = done_q;
  assign data_o = data_q;

  // gap trackers for the timing checks
  logic [CW-1:0] data_age_q, ack_hi_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_age_q <= '0;
      ack_hi_q   <= '0;
    end else begin
      if (take_o) data_age_q <= '0;
      else if (data_age_q != CW'(SETUP_CYC)) data_age_q <= data_age_q + 1'b1;
      if (!ack_i) ack_hi_q <= '0;
      else if (ack_hi_q != CW'(HOLD_CYC)) ack_hi_q <= ack_hi_q + 1'b1;
    end
  end

  p_req_rise_ack_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> !ack_i);
  p_req_fall_ack_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_q) |-> ack_i);
  p_setup_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> data_age_q >= CW'(SETUP_CYC));
  p_data_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !ack_i) |=> $stable(data_q));
  p_req_fall_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_q) |-> ack_hi_q >= CW'(HOLD_CYC));
  p_sess_covers_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> sess_q);
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/hs_link_rx.sv
`timescale 1ns/1ps
module hs_link_rx
  import hs_link_pkg::*;
#(
  parameter int DW        = 8,
  parameter int AW        = 4,
  parameter int HOLD_CYC  = 2,
  parameter int BASE_ADDR = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          sess_i,
  input  logic [DW-1:0] data_i,
  output logic          ack_o,
  output logic [DW-1:0] data_o,
  output logic [AW-1:0] addr_o,
  output logic          valid_o
);
  localparam int CW = cnt_width(HOLD_CYC, 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);
  localparam logic [AW-1:0] BASE      = AW'(BASE_ADDR);

  rx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic          ack_q, valid_q, sess_q;
  logic [DW-1:0] data_q;
  logic [AW-1:0] addr_q, next_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= RX_IDLE;
      cnt_q       <= '0;
      ack_q       <= 1'b0;
      valid_q     <= 1'b0;
      sess_q      <= 1'b0;
      data_q      <= '0;
      addr_q      <= '0;
      next_addr_q <= BASE;
    end else begin
      valid_q <= 1'b0;
      sess_q  <= sess_i;
      if (sess_i && !sess_q) next_addr_q <= BASE;
      case (state_q)
        RX_IDLE: begin
          if (!req_i) begin
            cnt_q <= '0;
          end else if (cnt_q == HOLD_LAST) begin
            cnt_q       <= '0;
            ack_q       <= 1'b1;
            valid_q     <= 1'b1;
            data_q      <= data_i;
            addr_q      <= next_addr_q;
            next_addr_q <= next_addr_q + 1'b1;
            state_q     <= RX_ACK;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_ACK: if (!req_i) begin
          ack_q   <= 1'b0;
          state_q <= RX_IDLE;
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign ack_o   = ack_q;
  assign data_o  = data_q;
  assign addr_o  = addr_q;
  assign valid_o = valid_q;

  logic [CW-1:0] req_hi_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       req_hi_q <= '0;
    else if (!req_i)                   req_hi_q <= '0;
    else if (req_hi_q != CW'(HOLD_CYC)) req_hi_q <= req_hi_q + 1'b1;
  end

  p_ack_rise_req_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |-> req_i);
  p_ack_fall_req_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_q) |-> !req_i);
  p_ack_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |-> req_hi_q >= CW'(HOLD_CYC));
  p_valid_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
endmodule

// File: rtl/hs_link_top.sv
`timescale 1ns/1ps
module hs_link_top #(
  parameter int DW        = 8,
  parameter int AW        = 4,
  parameter int LW        = 3,
  parameter int SETUP_CYC = 3,
  parameter int HOLD_CYC  = 2,
  parameter int BASE_ADDR = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [LW-1:0] burst_len_i,
  input  logic [DW-1:0] data_i,
  output logic          take_o,
  output logic          done_o,
  output logic [DW-1:0] rx_data_o,
  output logic [AW-1:0] rx_addr_o,
  output logic          rx_valid_o,
  output logic          link_req_o,
  output logic          link_ack_o,
  output logic          link_sess_o,
  output logic [DW-1:0] link_data_o
);
  logic          req, ack, sess;
  logic [DW-1:0] ldata;

  hs_link_tx #(
    .DW(DW), .LW(LW), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go_i),
    .len_i  (burst_len_i),
    .data_i (data_i),
    .ack_i  (ack),
    .take_o (take_o),
    .done_o (done_o),
    .req_o  (req),
    .sess_o (sess),
    .data_o (ldata)
  );

  hs_link_rx #(
    .DW(DW), .AW(AW), .HOLD_CYC(HOLD_CYC), .BASE_ADDR(BASE_ADDR)
  ) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req),
    .sess_i  (sess),
    .data_i  (ldata),
    .ack_o   (ack),
    .data_o  (rx_data_o),
    .addr_o  (rx_addr_o),
    .valid_o (rx_valid_o)
  );

  assign link_req_o  = req;
  assign link_ack_o  = ack;
  assign link_sess_o = sess;
  assign link_data_o = ldata;
endmodule

// File: tb/hs_link_top_tb.sv
`timescale 1ns/1ps
module hs_link_top_tb;
  localparam int DW = 8, AW = 4, LW = 3, SETUP = 3, HOLD = 2, BASE = 12;
  localparam int PERIOD = SETUP + 2*HOLD + 2;

  logic          clk = 1'b0, rst_n = 1'b0, go = 1'b0;
  logic [LW-1:0] len = '0;
  logic [DW-1:0] din = '0;
  logic          take, done, rx_valid, l_req, l_ack, l_sess;
  logic [DW-1:0] rx_data, l_data;
  logic [AW-1:0] rx_addr;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  hs_link_top #(
    .DW(DW), .AW(AW), .LW(LW), .SETUP_CYC(SETUP), .HOLD_CYC(HOLD), .BASE_ADDR(BASE)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .go_i(go), .burst_len_i(len), .data_i(din),
    .take_o(take), .done_o(done), .rx_data_o(rx_data), .rx_addr_o(rx_addr),
    .rx_valid_o(rx_valid), .link_req_o(l_req), .link_ack_o(l_ack),
    .link_sess_o(l_sess), .link_data_o(l_data)
  );

  function automatic logic [DW-1:0] word_of(int seed, int idx);
    return DW'(seed*37 + idx*29 + idx*idx*3);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_idle(string req);
    check(l_req == 0, req, int'(l_req), 0);
    check(l_ack == 0, req, int'(l_ack), 0);
    check(l_sess == 0, req, int'(l_sess), 0);
    check(done == 0, req, int'(done), 0);
    check(rx_valid == 0, req, int'(rx_valid), 0);
    check(take == 0, req, int'(take), 0);
  endtask

  task automatic run_session(int len_m1, int seed, bit hold_go);
    int n = len_m1 + 1;
    int got = 0, cyc = 0, idx = 0, c_data = 0, c_req = 0, c_ack = 0;
    bit pend, done_seen = 0, p_req, p_ack;
    logic [DW-1:0] p_data;
    @(negedge clk);
    len = LW'(len_m1);
    din = word_of(seed, 0);
    go  = 1'b1;
    #1;
    check(take == 1, "R6 start take", int'(take), 1);
    pend = take; p_req = l_req; p_ack = l_ack; p_data = l_data;
    while (!done_seen && cyc < n*PERIOD + 20) begin
      @(negedge clk);
      cyc++;
      if (!hold_go) go = 1'b0;
      if (pend) begin
        idx++;
        din = word_of(seed, idx);
      end
      #1;
      pend = take;
      if (l_data != p_data) c_data = cyc;
      if (l_req && !p_req) begin
        check(!l_ack, "R2 req rise", int'(l_ack), 0);
        check(cyc - c_data >= SETUP, "R3 setup gap", cyc - c_data, SETUP);
        c_req = cyc;
      end
      if (l_ack && !p_ack) begin
        check(l_req, "R2 ack rise", int'(l_req), 1);
        check(cyc - c_req == HOLD, "R4 ack gap", cyc - c_req, HOLD);
        c_ack = cyc;
      end
      if (!l_req && p_req) begin
        check(l_ack, "R2 req fall", int'(l_ack), 1);
        check(cyc - c_ack == HOLD, "R5 req gap", cyc - c_ack, HOLD);
      end
      if (!l_ack && p_ack) check(!l_req, "R2 ack fall", int'(l_req), 0);
      if (p_req && !p_ack) check(l_data == p_data, "R3 data stable", int'(l_data), int'(p_data));
      if (!done) check(l_sess, "R6 session flag", int'(l_sess), 1);
      if (rx_valid) begin
        check(rx_data == word_of(seed, got), "R7 data", int'(rx_data), int'(word_of(seed, got)));
        check(rx_addr == AW'(BASE + got), "R8 addr", int'(rx_addr), int'(AW'(BASE + got)));
        got++;
      end
      if (done) begin
        done_seen = 1;
        go = 1'b0;
      end
      p_req = l_req; p_ack = l_ack; p_data = l_data;
    end
    check(done_seen, "R9 done seen", int'(done_seen), 1);
    check(got == n, hold_go ? "R10 word count" : "R6 word count", got, n);
    check(cyc == n*PERIOD + 1, hold_go ? "R10 latency" : "R9 latency", cyc, n*PERIOD + 1);
    @(negedge clk);
    #1;
    check(done == 0, "R9 done pulse", int'(done), 0);
    check(l_sess == 0, "R6 session end", int'(l_sess), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check_idle("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check_idle("R1 after release");

    for (int s = 0; s < 3; s++)
      for (int l = 0; l < 8; l++)
        run_session(l, s*11 + l + 1, 1'b0);

    run_session(7, 99, 1'b1);
    run_session(2, 50, 1'b1);

    // reset in the middle of a burst
    @(negedge clk);
    len = LW'(7);
    din = 8'h3c;
    go  = 1'b1;
    @(negedge clk);
    go = 1'b0;
    repeat (15) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_idle("R1 mid-burst reset");
    @(negedge clk);
    rst_n = 1'b1;
    run_session(3, 77, 1'b0);  // R8: address restarts at base

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule